// File: doc/BRIEF.md
# PHY Register Access Port

This block gives a processor indirect access to the byte-wide configuration registers inside an attached PHY through one 32-bit control word. Software first writes the target register number and the byte to store, with both request flags clear. It then writes the same word again with either the write flag or the read flag set. The block copies the fields into private holding registers and presents one transaction on the PHY-side bus. When the PHY reports completion, the block raises a completion flag in the control word.

The completion flag follows a four-phase handshake. It stays high for as long as software keeps a request flag set. It drops one cycle after software clears both flags. Only after that can a new transaction start. For a read, the byte returned by the PHY is kept in a read-only field of the control word until the next read completes.

The PHY-side bus is a valid/ready pair. `phy_valid` is the valid signal and `phy_done` is the ready signal, and a transfer happens on a clock edge where both are high. The PHY may hold `phy_done` low for as many cycles as it needs. While it does, the block keeps `phy_valid`, `phy_we`, `phy_addr` and `phy_wdata` unchanged. `phy_rdata` is sampled only on the transfer edge of a read.

Top module: `phy_acc_port`

## Requirements
- R1: After reset the control word reads all zeros, `phy_valid` is low, and no request or acknowledge is pending.
- R2: Control word layout: register number in bits [5:0], write byte in bits [15:8], returned read byte in bits [23:16], write request in bit 24, read request in bit 25, acknowledge in bit 26. All other bits read 0. A CPU write updates bits [5:0], [15:8], 24 and 25 and leaves the rest unchanged.
- R3: When the write request is set while idle, one PHY transfer with `phy_we`=1 stores the latched byte at the latched register number.
- R4: When the read request is set while idle, one PHY transfer with `phy_we`=0 is made, and the returned byte appears in bits [23:16]. That field changes only when a read transfer completes.
- R5: The acknowledge bit rises in the cycle after the PHY transfer. It stays 1, with no further PHY transfer, for as long as either request bit is set.
- R6: The acknowledge bit returns to 0 exactly two cycles after the CPU write that clears both request bits. It is still 1 in the cycle between.
- R7: If both request bits are set together, only a write transfer is made, and the read byte field keeps its value.
- R8: The register number and write byte are captured when the transaction starts. CPU writes that change them during the transaction do not alter the PHY bus or the stored result.
- R9: Requests that are set or changed while the acknowledge is high start no new transaction.
- R10: While `phy_valid` is high and `phy_done` is low, `phy_valid`, `phy_we`, `phy_addr` and `phy_wdata` hold their values. The acknowledge does not rise before the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe for the control word |
| cpu_wdata | input | 32 | CPU write value |
| cpu_word | output | 32 | Current control word as the CPU reads it |
| phy_valid | output | 1 | PHY transaction pending (valid) |
| phy_we | output | 1 | 1 for a write transaction, 0 for a read |
| phy_addr | output | ADDR_W | PHY register number |
| phy_wdata | output | DATA_W | Byte to store in the PHY |
| phy_rdata | input | DATA_W | Byte returned by the PHY |
| phy_done | input | 1 | PHY completes the transfer (ready) |

## Verification
The bench uses the default build: a 6-bit register number and an 8-bit data lane. This keeps the whole 64-entry PHY register space small enough to sweep in full. Every register is written with a value computed from its number and then read back. The PHY model's response latency cycles from zero to three wait cycles, and a longer stall is used to exercise back-pressure. Separate directed transactions cover the cases where both request flags are set together, where fields are rewritten while a transaction is in flight, and where requests are raised while the acknowledge is high.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int WORD_W    = 32;
  localparam int LANE_W    = 8;
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } acc_state_e;
endpackage

// File: rtl/phy_acc_word_reg.sv
module phy_acc_word_reg
  import phy_acc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_req_q,
  output logic              rd_req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_req_q <= 1'b0;
      rd_req_q <= 1'b0;
    end else if (cpu_we) begin
      addr_q   <= cpu_wdata[ADDR_LSB +: ADDR_W];
      wdata_q  <= cpu_wdata[WDATA_LSB +: DATA_W];
      wr_req_q <= cpu_wdata[WR_BIT];
      rd_req_q <= cpu_wdata[RD_BIT];
    end
  end

  AST_REQ_FOLLOWS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> (wr_req_q == $past(cpu_wdata[WR_BIT]))) else $error("AST_REQ_FOLLOWS_CPU"); // R2
endmodule

// File: rtl/phy_acc_xact.sv
module phy_acc_xact
  import phy_acc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              phy_done,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              phy_valid,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata_q
);
  acc_state_e        state_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic              any_req;
  logic              xfer;

  assign any_req = wr_req | rd_req;
  assign xfer    = (state_q == ST_BUSY) & phy_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_wr_q     <= 1'b0;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_req) begin
          state_q     <= ST_BUSY;
          op_wr_q     <= wr_req;
          lat_addr_q  <= addr_in;
          lat_wdata_q <= wdata_in;
        end
        ST_BUSY: if (phy_done) begin
          state_q <= ST_ACK;
          if (!op_wr_q) rdata_q <= phy_rdata;
        end
        ST_ACK: if (!any_req) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phy_valid = (state_q == ST_BUSY);
  assign phy_we    = op_wr_q;
  assign phy_addr  = lat_addr_q;
  assign phy_wdata = lat_wdata_q;
  assign ack       = (state_q == ST_ACK);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_valid && !phy_done) |=> (phy_valid && $stable(phy_addr) && $stable(phy_wdata) && $stable(phy_we))) else $error("AST_HOLD_STALLED"); // R10
  AST_ACK_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ack) else $error("AST_ACK_AFTER_XFER"); // R5
  AST_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any_req) |=> (ack && !phy_valid)) else $error("AST_ACK_KEEP"); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any_req) |=> !ack) else $error("AST_ACK_RELEASE"); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && phy_valid)) else $error("AST_NO_OVERLAP"); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_valid && !ack && wr_req && rd_req) |=> (phy_valid && phy_we)) else $error("AST_WRITE_WINS"); // R7
  AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer && !op_wr_q) |=> $stable(rdata_q)) else $error("AST_RDATA_STEADY"); // R4
endmodule

// File: rtl/phy_acc_port.sv
module phy_acc_port
  import phy_acc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_word,
  output logic              phy_valid,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              phy_done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_req_q;
  logic              rd_req_q;
  logic              ack;

  phy_acc_word_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_we   (cpu_we),
    .cpu_wdata(cpu_wdata),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .wr_req_q (wr_req_q),
    .rd_req_q (rd_req_q)
  );

  phy_acc_xact #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xact (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_in  (addr_q),
    .wdata_in (wdata_q),
    .wr_req   (wr_req_q),
    .rd_req   (rd_req_q),
    .phy_done (phy_done),
    .phy_rdata(phy_rdata),
    .phy_valid(phy_valid),
    .phy_we   (phy_we),
    .phy_addr (phy_addr),
    .phy_wdata(phy_wdata),
    .ack      (ack),
    .rdata_q  (rdata_q)
  );

  always_comb begin
    cpu_word                           = '0;
    cpu_word[ADDR_LSB  +: ADDR_W]      = addr_q;
    cpu_word[WDATA_LSB +: DATA_W]      = wdata_q;
    cpu_word[RDATA_LSB +: DATA_W]      = rdata_q;
    cpu_word[WR_BIT]                   = wr_req_q;
    cpu_word[RD_BIT]                   = rd_req_q;
    cpu_word[ACK_BIT]                  = ack;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (cpu_word == 32'd0 && !phy_valid)) else $error("AST_RESET_IDLE"); // R1
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_valid) |-> $past(!ack)) else $error("AST_START_ONLY_IDLE"); // R9
endmodule

// File: tb/sim_phy_acc_port.sv
module sim_phy_acc_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_word;
  logic        phy_valid, phy_we;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata;
  logic [7:0]  phy_rdata = '0;
  logic        phy_done = 1'b0;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int xfers  = 0;
  logic [7:0] pmem [64];
  logic [7:0] emem [64];

  always #4 clk = ~clk;

  phy_acc_port #(.ADDR_W(6), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_word(cpu_word), .phy_valid(phy_valid), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
    .phy_done(phy_done)
  );

  // PHY model: answers after lat wait cycles
  initial begin
    for (int i = 0; i < 64; i++) pmem[i] = 8'(i) ^ 8'hA5;
    forever begin
      @(negedge clk);
      if (phy_done) begin
        phy_done = 1'b0;
      end else if (phy_valid) begin
        if (wcnt >= lat) begin
          phy_done  = 1'b1;
          phy_rdata = pmem[phy_addr];
          if (phy_we) pmem[phy_addr] = phy_wdata;
          xfers++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int a, input int d, input bit wr, input bit rd);
    logic [31:0] w;
    w = '0;
    w[5:0] = 6'(a);
    w[15:8] = 8'(d);
    w[24] = wr;
    w[25] = rd;
    return w;
  endfunction

  task automatic cpu_wr(input logic [31:0] w);
    cpu_we = 1'b1;
    cpu_wdata = w;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic wait_ack(input bit v);
    for (int k = 0; k < 300; k++) begin
      if (cpu_word[26] == v) break;
      @(negedge clk);
    end
  endtask

  task automatic release_req(input int a, input int d);
    cpu_wr(mk(a, d, 0, 0));
    chk(cpu_word[26] == 1'b1, "R6 ack held one cycle", int'(cpu_word[26]), 1);
    @(negedge clk);
    chk(cpu_word[26] == 1'b0, "R6 ack dropped", int'(cpu_word[26]), 0);
  endtask

  task automatic txn(input int a, input int d, input bit wr, input bit rd);
    cpu_wr(mk(a, d, 0, 0));
    chk(cpu_word[15:0] == {8'(d), 2'b00, 6'(a)}, "R2 field readback", int'(cpu_word[15:0]), int'({8'(d), 2'b00, 6'(a)}));
    cpu_wr(mk(a, d, wr, rd));
    wait_ack(1'b1);
    chk(cpu_word[26] == 1'b1, "R5 ack raised", int'(cpu_word[26]), 1);
    release_req(a, d);
  endtask

  initial begin
    int x0;
    int old_rd;
    for (int i = 0; i < 64; i++) emem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpu_word == 32'd0, "R1 word after reset", int'(cpu_word), 0);
    chk(phy_valid == 1'b0, "R1 bus idle", int'(phy_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: read-only fields ignore CPU writes
    cpu_wr(32'hFFFF_FFFF & ~32'h0300_0000);
    chk(cpu_word == 32'h0000_FF3F, "R2 layout", int'(cpu_word), 32'h0000_FF3F);

    // R3: write sweep over all registers
    for (int a = 0; a < 64; a++) begin
      lat = a % 4;
      x0 = xfers;
      txn(a, (a * 37 + 11) & 255, 1, 0);
      emem[a] = 8'((a * 37 + 11) & 255);
      chk(pmem[a] == emem[a], "R3 write stored", int'(pmem[a]), int'(emem[a]));
      chk(xfers == x0 + 1, "R3 one transfer", xfers - x0, 1);
    end

    // R4: read sweep
    for (int a = 0; a < 64; a++) begin
      lat = (a + 1) % 4;
      txn(a, 8'h00, 0, 1);
      chk(cpu_word[23:16] == emem[a], "R4 read byte", int'(cpu_word[23:16]), int'(emem[a]));
      chk(pmem[a] == emem[a], "R4 read leaves PHY", int'(pmem[a]), int'(emem[a]));
    end

    // R5: ack holds while request stays set
    lat = 1;
    x0 = xfers;
    cpu_wr(mk(12, 8'h3C, 0, 0));
    cpu_wr(mk(12, 8'h3C, 1, 0));
    wait_ack(1'b1);
    repeat (6) @(negedge clk);
    chk(cpu_word[26] == 1'b1, "R5 ack still high", int'(cpu_word[26]), 1);
    chk(xfers == x0 + 1, "R5 no extra transfer", xfers - x0, 1);
    // R9: raise read while ack high
    cpu_wr(mk(20, 8'h3C, 1, 1));
    repeat (3) @(negedge clk);
    chk(phy_valid == 1'b0, "R9 no start while ack", int'(phy_valid), 0);
    release_req(20, 8'h3C);
    repeat (3) @(negedge clk);
    chk(xfers == x0 + 1, "R9 no new transaction", xfers - x0, 1);
    emem[12] = 8'h3C;
    chk(pmem[12] == 8'h3C, "R5 stored", int'(pmem[12]), 8'h3C);

    // R7: both flags -> write only
    old_rd = int'(cpu_word[23:16]);
    x0 = xfers;
    cpu_wr(mk(3, 8'h77, 0, 0));
    cpu_wr(mk(3, 8'h77, 1, 1));
    @(negedge clk);
    chk(phy_valid && phy_we, "R7 write chosen", int'(phy_we), 1);
    wait_ack(1'b1);
    release_req(3, 8'h77);
    emem[3] = 8'h77;
    chk(pmem[3] == 8'h77, "R7 write stored", int'(pmem[3]), 8'h77);
    chk(int'(cpu_word[23:16]) == old_rd, "R7 read byte kept", int'(cpu_word[23:16]), old_rd);
    chk(xfers == x0 + 1, "R7 single transfer", xfers - x0, 1);

    // R8 + R10: change fields mid-flight under a long stall
    lat = 8;
    cpu_wr(mk(5, 8'h5A, 0, 0));
    cpu_wr(mk(5, 8'h5A, 1, 0));
    @(negedge clk);
    chk(phy_valid == 1'b1, "R10 valid raised", int'(phy_valid), 1);
    cpu_wr(mk(9, 8'hC3, 1, 0));
    repeat (3) @(negedge clk);
    chk(phy_valid && phy_addr == 6'd5, "R8 addr latched", int'(phy_addr), 5);
    chk(phy_wdata == 8'h5A, "R8 data latched", int'(phy_wdata), 8'h5A);
    chk(cpu_word[26] == 1'b0, "R10 no early ack", int'(cpu_word[26]), 0);
    wait_ack(1'b1);
    release_req(9, 8'hC3);
    emem[5] = 8'h5A;
    chk(pmem[5] == 8'h5A, "R8 stored at latched addr", int'(pmem[5]), 8'h5A);
    chk(pmem[9] == emem[9], "R8 other addr untouched", int'(pmem[9]), int'(emem[9]));

    report();
  end
endmodule